// File: doc/BRIEF.md
# Two-Character Serial Segment Frame Transmitter

This block sits on the host side of a two-character segmented display whose receiver takes a framed bit stream over a clock, data and active-low enable line. A 34-bit segment image (17 segments for each of two characters) is handed over on a valid/ready handshake. The block then sends one frame. The frame opens with a fixed 1 start bit, carries the 34 image bits, and ends with one spare bit that is always 0, for 36 serial clock pulses in total. There is no load or latch strobe: the receiver commits the frame on its 36th clock.

The serial clock comes from a divider parameter `HALF_CYC`, which is the number of system cycles in each serial clock phase. Data changes only when the serial clock falls. Each bit is therefore stable for a full low phase before the rising edge and a full high phase after it. With the default of 100 at a 100 MHz system clock, the serial clock runs at 0.5 MHz. Setup and hold are each 1 µs, well beyond the 300 ns and 100 ns the receiver needs.

The control is a four-state machine:
- `ST_IDLE`: waiting. `img_valid` moves it to `ST_SETUP` and loads the frame.
- `ST_SETUP`: serial clock low, bit on the line. When the phase timer expires it moves to `ST_STROBE`.
- `ST_STROBE`: serial clock high. When the timer expires it moves to `ST_SETUP` and shifts to the next bit, or moves to `ST_GAP` after the last bit.
- `ST_GAP`: enable inactive for two phases, then back to `ST_IDLE` with a done pulse.

Top module: `sdt_frame_tx`

## Requirements
- R1: The first bit of every frame is 1. Frame position k (1 to 34) carries `img_data[k-1]`, so `img_data[0]` is the first segment of character 1 and `img_data[17]` is the first segment of character 2. Position 35 is always 0.
- R2: Exactly 36 rising `ser_clk` edges occur while `ser_en_n` is low in one frame.
- R3: Every low phase and every high phase of `ser_clk` inside a frame lasts exactly `HALF_CYC` system cycles. Each bit is therefore stable for `HALF_CYC` cycles before and after its rising edge.
- R4: `ser_data` changes only in the same cycle that `ser_clk` falls or that `ser_en_n` changes.
- R5: `ser_en_n` falls `HALF_CYC` cycles before the first rising edge and rises in the cycle of the 36th falling edge. `ser_clk` is high only while `ser_en_n` is low, and no other strobe exists.
- R6: Between two frames, `ser_en_n` stays high for at least `2*HALF_CYC` cycles, even when images are offered back to back.
- R7: An image is taken on a rising clock edge with `img_valid` and `img_ready` both high. `img_ready` is high only when idle. `img_valid` and `img_data` are ignored while `img_ready` is low.
- R8: `frame_done` is high for exactly one cycle: the first cycle in which `img_ready` is high again after a frame.
- R9: After reset and whenever idle: `img_ready`=1, `busy`=0, `ser_clk`=0, `ser_data`=0, `ser_en_n`=1, `frame_done`=0.
- R10: `busy` is high from the cycle after acceptance until the frame and its gap are over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| img_valid | input | 1 | Image offered |
| img_data | input | DIGITS*SEGS (34) | Segment image, character 1 in the low half |
| img_ready | output | 1 | Idle, image can be taken |
| busy | output | 1 | Frame or inter-frame gap in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, idles low |
| ser_en_n | output | 1 | Active-low frame enable |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Bit order.** A walking one and per-character images would catch frames sent MSB first, or frames without the start bit. A design that mis-sequenced the bits would show up there as misplaced positions, and the all-ones image checks that the spare bit stays 0.
- **Timing.** Phase widths and the lead before the first edge are measured in system cycles. A design that changed data on the rising edge, or shortened the first low phase, would show a setup or hold of zero.
- **Back-to-back images.** Images offered with `img_valid` held high would reveal a missing inter-frame gap.
- **Handshake while busy.** A second image driven mid-frame would reveal a handshake that overwrote the frame in flight or started a stray frame.
- **Frame length and done pulse.** An off-by-one bit counter would give 35 or 37 clocks, and a done pulse longer than one cycle would also be caught.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    // Transmitter control states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_GAP    = 2'd3
    } sdt_state_e;

    localparam logic START_BIT_VAL = 1'b1;

endpackage

// File: rtl/sdt_phase_timer.sv
// Down-counting phase timer: load value N-1 to get N cycles before expiry.
module sdt_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/sdt_frame_builder.sv
// Assembles the serial frame: start bit, character fields in order, spare zeros.
module sdt_frame_builder #(
    parameter int DIGITS = 2,
    parameter int SEGS   = 17,
    parameter int SPARE  = 1,
    localparam int FRAME_BITS = 1 + DIGITS * SEGS + SPARE
) (
    input  logic [DIGITS*SEGS-1:0] img,
    output logic [FRAME_BITS-1:0]  frame
);

    assign frame[0] = sdt_pkg::START_BIT_VAL;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign frame[1 + d*SEGS +: SEGS] = img[d*SEGS +: SEGS];
    end

    if (SPARE > 0) begin : g_spare
        assign frame[FRAME_BITS-1 -: SPARE] = '0;
    end

endmodule

// File: rtl/sdt_bit_shifter.sv
// Holds the frame, presents the current bit, tracks the bit index.
module sdt_bit_shifter #(
    parameter int FRAME_BITS = 36,
    localparam int IW = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  shift,
    output logic                  bit_out,
    output logic                  last
);

    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sreg_q;
    logic [IW-1:0]         idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            sreg_q <= frame_in;
            idx_q  <= '0;
        end else if (shift) begin
            sreg_q <= {1'b0, sreg_q[FRAME_BITS-1:1]};
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign bit_out = sreg_q[0];
    assign last    = (idx_q == LAST_IDX);

endmodule

// File: rtl/sdt_frame_tx.sv
module sdt_frame_tx
    import sdt_pkg::*;
#(
    parameter int HALF_CYC = 100,
    parameter int DIGITS   = 2,
    parameter int SEGS     = 17,
    parameter int SPARE    = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   img_valid,
    input  logic [DIGITS*SEGS-1:0] img_data,
    output logic                   img_ready,
    output logic                   busy,
    output logic                   frame_done,
    output logic                   ser_clk,
    output logic                   ser_data,
    output logic                   ser_en_n
);

    localparam int FRAME_BITS = 1 + DIGITS * SEGS + SPARE;
    localparam int GAP_CYC    = 2 * HALF_CYC;
    localparam int TW         = $clog2(GAP_CYC + 1);
    localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);

    sdt_state_e state_q, state_d;

    logic                  tmr_load;
    logic [TW-1:0]         tmr_val;
    logic                  tmr_expire;
    logic                  sh_load;
    logic                  sh_shift;
    logic                  sh_bit;
    logic                  sh_last;
    logic                  done_q;
    logic [FRAME_BITS-1:0] frame_w;

    sdt_frame_builder #(
        .DIGITS (DIGITS),
        .SEGS   (SEGS),
        .SPARE  (SPARE)
    ) u_build (
        .img   (img_data),
        .frame (frame_w)
    );

    sdt_phase_timer #(
        .W (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    sdt_bit_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .frame_in (frame_w),
        .shift    (sh_shift),
        .bit_out  (sh_bit),
        .last     (sh_last)
    );

    // Next-state and datapath control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = HALF_LD;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (img_valid) begin
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    state_d  = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        tmr_val = GAP_LD;
                        state_d = ST_GAP;
                    end else begin
                        sh_shift = 1'b1;
                        state_d  = ST_SETUP;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expire) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register and end-of-frame flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_GAP) && tmr_expire;
        end
    end

    // Moore outputs from the state register
    always_comb begin
        img_ready  = 1'b0;
        busy       = 1'b1;
        ser_clk    = 1'b0;
        ser_data   = 1'b0;
        ser_en_n   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                img_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_SETUP: begin
                ser_en_n = 1'b0;
                ser_data = sh_bit;
            end
            ST_STROBE: begin
                ser_en_n = 1'b0;
                ser_clk  = 1'b1;
                ser_data = sh_bit;
            end
            ST_GAP: begin
                ser_en_n = 1'b1;
            end
        endcase
        frame_done = done_q;
    end

endmodule

// File: rtl/sdt_frame_tx_chk.sv
module sdt_frame_tx_chk #(
    parameter int HALF_CYC   = 100,
    parameter int FRAME_BITS = 36
) (
    input logic clk,
    input logic rst_n,
    input logic img_valid,
    input logic img_ready,
    input logic busy,
    input logic frame_done,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_en_n
);

    localparam logic [15:0] HALF_V = 16'(HALF_CYC);
    localparam logic [15:0] GAP_V  = 16'(2 * HALF_CYC);
    localparam logic [7:0]  FB_V   = 8'(FRAME_BITS);

    logic        clk_p;
    logic [7:0]  rise_cnt;
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;
    logic [15:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_p    <= 1'b0;
            rise_cnt <= '0;
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            gap_cnt  <= GAP_V;
        end else begin
            clk_p    <= ser_clk;
            if (ser_en_n)                rise_cnt <= '0;
            else if (ser_clk && !clk_p)  rise_cnt <= rise_cnt + 1'b1;
            hi_cnt   <= ser_clk ? hi_cnt + 1'b1 : '0;
            lo_cnt   <= (ser_clk || ser_en_n) ? '0 : lo_cnt + 1'b1;
            if (!ser_en_n)               gap_cnt <= '0;
            else if (gap_cnt < GAP_V)    gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en_n) |-> ser_data); // R1
    AST_RISE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en_n) |-> rise_cnt == FB_V); // R2
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> hi_cnt == HALF_V); // R3
    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> lo_cnt == HALF_V); // R3
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> ($fell(ser_clk) || !$stable(ser_en_n))); // R4
    AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !ser_en_n); // R5
    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en_n) |-> $fell(ser_clk)); // R5
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en_n) |-> gap_cnt >= GAP_V); // R6
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_n |-> !img_ready); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> img_ready); // R8
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> (ser_en_n && !ser_clk && !ser_data && !busy)); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (img_valid && img_ready) |=> busy); // R10

endmodule

bind sdt_frame_tx sdt_frame_tx_chk #(
    .HALF_CYC   (HALF_CYC),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .img_valid  (img_valid),
    .img_ready  (img_ready),
    .busy       (busy),
    .frame_done (frame_done),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_en_n   (ser_en_n)
);

// File: tb/sdt_frame_tx_tb.sv
`timescale 1ns/1ps
module sdt_frame_tx_tb;

    localparam int HALF = 100;
    localparam int NV   = 6;
    localparam int FB   = 36;

    // Stimulus table: image; expected frame is computed by exp_frame()
    localparam logic [33:0] VEC [NV] = '{
        34'h0_0000_0000,
        34'h3_FFFF_FFFF,
        34'h1_5555_5555,
        34'h0_0000_0001,
        34'h0_0001_FFFF,
        34'h3_FFFE_0000
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        img_valid = 1'b0;
    logic [33:0] img_data = '0;
    logic        img_ready, busy, frame_done, ser_clk, ser_data, ser_en_n;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    sdt_frame_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .img_valid  (img_valid),
        .img_data   (img_data),
        .img_ready  (img_ready),
        .busy       (busy),
        .frame_done (frame_done),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_en_n   (ser_en_n)
    );

    // Serial line monitor, sampled on the falling system clock edge
    logic        p_clk = 0, p_en = 1, p_data = 0;
    logic [35:0] cap;
    int nrise, nframes, since_chg, since_rise, hi_len;
    int setup_min, hold_min, hi_min, hi_max, first_setup, gap_cnt, last_gap;
    bit seen_rise, end_ok;

    initial begin
        nrise = 0; nframes = 0; since_chg = 0; since_rise = 0; hi_len = 0;
        setup_min = 0; hold_min = 0; hi_min = 0; hi_max = 0; first_setup = 0;
        gap_cnt = 0; last_gap = 0; seen_rise = 0; end_ok = 0; cap = '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ser_en_n && p_en) begin
                nframes++; nrise = 0; cap = '0; last_gap = gap_cnt;
                setup_min = 1 << 30; hold_min = 1 << 30; hi_min = 1 << 30;
                hi_max = 0; seen_rise = 0; end_ok = 0; first_setup = 0;
            end
            gap_cnt = ser_en_n ? gap_cnt + 1 : 0;
            since_chg = (ser_data != p_data) ? 0 : since_chg + 1;
            if (ser_clk && !p_clk) begin
                since_rise = 0;
                seen_rise  = 1;
                if (nrise == 0) first_setup = since_chg;
                if (nrise < FB) cap[nrise] = ser_data;
                nrise++;
                if (since_chg < setup_min) setup_min = since_chg;
                hi_len = 0;
            end else begin
                since_rise++;
            end
            if (ser_data != p_data && seen_rise && since_rise < hold_min)
                hold_min = since_rise;
            if (ser_clk) hi_len++;
            if (!ser_clk && p_clk) begin
                if (hi_len < hi_min) hi_min = hi_len;
                if (hi_len > hi_max) hi_max = hi_len;
            end
            if (ser_en_n && !p_en) end_ok = (!ser_clk && p_clk);
            p_clk = ser_clk; p_en = ser_en_n; p_data = ser_data;
        end
    end

    function automatic logic [35:0] exp_frame(input logic [33:0] img);
        return {1'b0, img, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one image, wait for the frame to finish, check the handshake
    task automatic send(input logic [33:0] img);
        @(negedge clk);
        img_valid = 1'b1;
        img_data  = img;
        while (!img_ready) @(negedge clk);
        @(negedge clk);
        img_valid = 1'b0;
        chk(busy && !img_ready, "R10", "busy after accept", {busy, img_ready}, 2'b10);
        while (!frame_done) @(negedge clk);
        chk(img_ready && !busy, "R8", "done with ready", {img_ready, busy}, 2'b10);
        @(negedge clk);
        chk(!frame_done, "R8", "done one cycle", frame_done, 0);
    endtask

    task automatic check_frame(input logic [33:0] img, input string tag);
        chk(cap == exp_frame(img), "R1", {tag, " frame bits"}, cap, exp_frame(img));
        chk(nrise == FB, "R2", {tag, " rising edges"}, nrise, FB);
        chk(setup_min == HALF && hold_min == HALF, "R3", {tag, " setup/hold"},
            {setup_min[31:0], hold_min[31:0]}, {HALF[31:0], HALF[31:0]});
        chk(hi_min == HALF && hi_max == HALF, "R3", {tag, " high width"},
            {hi_min[31:0], hi_max[31:0]}, {HALF[31:0], HALF[31:0]});
        chk(first_setup == HALF && end_ok, "R5", {tag, " enable lead/end"},
            {first_setup[31:0], 31'd0, end_ok}, {HALF[31:0], 32'd1});
        chk(ser_en_n && !ser_clk && !ser_data, "R9", {tag, " idle lines"},
            {ser_en_n, ser_clk, ser_data}, 3'b100);
    endtask

    // Watchdog
    initial begin
        #(190000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int fr0;
        // R9: reset state
        #1;
        chk(img_ready == 1 && busy == 0, "R9", "reset handshake", {img_ready, busy}, 2'b10);
        chk(ser_clk == 0 && ser_data == 0 && ser_en_n == 1, "R9", "reset lines",
            {ser_clk, ser_data, ser_en_n}, 3'b001);
        chk(frame_done == 0, "R9", "reset done", frame_done, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(img_ready && !busy && ser_en_n && !ser_clk && !ser_data && !frame_done,
            "R9", "idle after reset", {img_ready, busy, ser_en_n, ser_clk, ser_data, frame_done},
            6'b101000);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i]);
            check_frame(VEC[i], $sformatf("vec%0d", i));
        end

        // R7: image offered while busy is ignored
        fr0 = nframes;
        @(negedge clk);
        img_valid = 1'b1; img_data = 34'h0_0F0F_0F0F;
        @(negedge clk);
        img_valid = 1'b0;
        repeat (500) @(negedge clk);
        img_valid = 1'b1; img_data = 34'h3_FFFF_0000;
        repeat (3) @(negedge clk);
        img_valid = 1'b0; img_data = '0;
        while (!frame_done) @(negedge clk);
        @(negedge clk);
        chk(cap == exp_frame(34'h0_0F0F_0F0F), "R7", "busy offer ignored",
            cap, exp_frame(34'h0_0F0F_0F0F));
        repeat (400) @(negedge clk);
        chk(nframes == fr0 + 1 && ser_en_n, "R7", "no stray frame", nframes - fr0, 1);

        // R6: back-to-back images
        send(34'h2_AAAA_AAAA);
        send(34'h1_2345_6789);
        chk(last_gap >= 2 * HALF, "R6", "inter-frame gap", last_gap, 2 * HALF);
        check_frame(34'h1_2345_6789, "b2b");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule